// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address by reading a four-level radix tree of translation tables from memory. A requester presents one address together with the kind of access (write, instruction fetch, user mode). The walker then reads one 64-bit entry per level through a single-outstanding request/response memory port. It starts from the frame number of the top-level table and ends with either a physical address plus the permissions merged along the path, or a fault with a 2-bit cause and the offending virtual address.

Mappings of 4 KB, 2 MB and 1 GB are supported: an entry at the third or second level with its size bit set ends the walk early. The write, user and no-execute bits of every entry on the path are combined, so a restriction at any level wins. Entries are only read. No translation is cached.

The controller is one state machine. `ST_IDLE` accepts a request and moves to `ST_L4` if the address is canonical, or straight to `ST_FAULT` if it is not. Each level state (`ST_L4`, `ST_L3`, `ST_L2`, `ST_L1`) issues one entry read and waits for its response. It then moves down to the next level state, or to `ST_DONE` on a leaf that passes the permission check, or to `ST_FAULT` on an absent entry or a permission violation. `ST_DONE` and `ST_FAULT` each last one cycle and return to `ST_IDLE`.

Top module: `pgw_top`

## Requirements
- R1: After reset, and whenever the walker is idle, `busy`, `mem_req_valid` and `done_valid` are low.
- R2: If bits 63:47 of the request address are not all equal, the walker reports a fault with code 0 in the cycle after acceptance and issues no memory read.
- R3: The entry read at each level goes to table base + index*8. The index is taken from virtual address bits 47:39 (level 4), 38:30 (level 3), 29:21 (level 2) and 20:12 (level 1). The level-4 base is `root_frame`*4096, and each later base is entry bits 51:12 times 4096.
- R4: A level-1 entry with bit 0 set maps a 4 KB page: the physical address is entry bits 51:12 followed by virtual bits 11:0 (so 0x803FE7F5CE through a level-1 entry at index 127 pointing to 0xC000 gives 0xC5CE).
- R5: An entry with bit 0 clear ends the walk with fault code 1, with `fault_vaddr` equal to the request address and no further reads.
- R6: A level-3 entry with bit 7 set maps a 1 GB frame: physical address = entry bits 51:30 followed by virtual bits 29:0, after two reads. Bit 7 in a level-4 entry has no effect.
- R7: A level-2 entry with bit 7 set maps a 2 MB frame: physical address = entry bits 51:21 followed by virtual bits 20:0, after three reads.
- R8: A write to a mapping where bit 1 is clear in any entry on the path faults with code 2, and a successful result never carries a nonzero code.
- R9: A user access where bit 2 is clear in any entry, or an execute access where bit 63 is set in any entry, faults with code 3. A write violation takes priority over this one.
- R10: On success, `done_writable` and `done_user` are the AND of bits 1 and 2 over all fetched entries, and `done_noexec` is the OR of bit 63.
- R11: One request at a time. `busy` stays high from acceptance through the result cycle, at most one entry read is outstanding, and `req_valid` is ignored while busy.
- R12: `done_valid` is a single-cycle pulse per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request, taken when idle |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_exec | input | 1 | Access is an instruction fetch |
| req_user | input | 1 | Access is from user mode |
| root_frame | input | PA_W-OFF_W | Frame number of the level-4 table |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Entry read request (one-cycle pulse) |
| mem_req_addr | output | PA_W | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Entry read data valid |
| mem_rsp_data | input | 64 | Entry read data |
| done_valid | output | 1 | Result valid (one-cycle pulse) |
| done_fault | output | 1 | Result is a fault |
| fault_code | output | 2 | 0 non-canonical, 1 absent, 2 write, 3 user/execute |
| fault_vaddr | output | VA_W | Faulting virtual address |
| done_paddr | output | PA_W | Translated physical address |
| done_writable | output | 1 | Merged write permission |
| done_user | output | 1 | Merged user permission |
| done_noexec | output | 1 | Merged no-execute |

## Verification
The properties assume that the memory side returns exactly one response for each entry read and never responds while no read is pending. They also assume that `req_vaddr` is stable in the cycle it is offered. The bench memory model answers each read exactly once, two cycles later, from a table image that is fixed before reset is released. Requests are driven as one-cycle pulses between clock edges, and a second request is deliberately offered mid-walk only to show that it is dropped.

// File: rtl/pgw_pkg.sv
`timescale 1ns/1ps
package pgw_pkg;
    localparam int ENT_W         = 64;
    localparam int ENT_BYTES_LOG = 3;
    localparam int WALK_LEVELS   = 4;

    // entry bit positions decoded by the walker
    localparam int BIT_PRESENT = 0;
    localparam int BIT_WRITE   = 1;
    localparam int BIT_USER    = 2;
    localparam int BIT_LEAF    = 7;
    localparam int BIT_NOEXEC  = 63;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L4,
        ST_L3,
        ST_L2,
        ST_L1,
        ST_DONE,
        ST_FAULT
    } walk_st_e;

    typedef enum logic [1:0] {
        FC_NONCANON = 2'd0,
        FC_ABSENT   = 2'd1,
        FC_WRITE    = 2'd2,
        FC_PRIV     = 2'd3
    } fault_e;

    typedef struct packed {
        logic wr;
        logic usr;
        logic nx;
    } perm_t;
endpackage

// File: rtl/pgw_index.sv
`timescale 1ns/1ps
module pgw_index #(
    parameter int VA_W   = 64,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 9,
    parameter int LEVELS = 4
) (
    input  logic [OFF_W+LEVELS*IDX_W-1:OFF_W] va_idx_bits,
    output logic [LEVELS-1:0][IDX_W-1:0]      idx
);
    // slot 0 is the level-1 index, slot LEVELS-1 the top-level index
    genvar g;
    generate
        for (g = 0; g < LEVELS; g++) begin : g_slice
            assign idx[g] = va_idx_bits[OFF_W + g*IDX_W +: IDX_W];
        end
    endgenerate
endmodule

// File: rtl/pgw_addr_gen.sv
`timescale 1ns/1ps
module pgw_addr_gen #(
    parameter int PA_W  = 52,
    parameter int OFF_W = 12,
    parameter int IDX_W = 9
) (
    input  logic [PA_W-OFF_W-1:0] table_frame,
    input  logic [IDX_W-1:0]      idx,
    output logic [PA_W-1:0]       entry_addr
);
    import pgw_pkg::*;

    logic [PA_W-1:0] base_bytes;
    logic [PA_W-1:0] idx_bytes;

    always_comb begin
        base_bytes = {table_frame, {OFF_W{1'b0}}};
        idx_bytes  = {{(PA_W-IDX_W){1'b0}}, idx} << ENT_BYTES_LOG;
        entry_addr = base_bytes + idx_bytes;
    end
endmodule

// File: rtl/pgw_leaf.sv
`timescale 1ns/1ps
module pgw_leaf #(
    parameter int PA_W     = 52,
    parameter int OFF_W    = 12,
    parameter int IDX_W    = 9,
    parameter int HUGE_TOP = 2
) (
    input  logic [PA_W-OFF_W-1:0]          frame,
    input  logic [OFF_W+HUGE_TOP*IDX_W-1:0] va_low,
    input  logic                           size_bit,
    input  logic [1:0]                     lvl,
    output logic [PA_W-1:0]                leaf_pa,
    output logic                           is_leaf
);
    localparam int FRAME_W = PA_W - OFF_W;

    logic [HUGE_TOP:0][PA_W-1:0] pa_cand;

    // level g leaf: frame bits above g*IDX_W, virtual bits below
    genvar g;
    generate
        for (g = 0; g <= HUGE_TOP; g++) begin : g_cand
            assign pa_cand[g] = {frame[FRAME_W-1:g*IDX_W], va_low[OFF_W+g*IDX_W-1:0]};
        end
    endgenerate

    always_comb begin
        leaf_pa = '0;
        for (int i = 0; i <= HUGE_TOP; i++) begin
            if (int'(lvl) == i) leaf_pa = pa_cand[i];
        end
        is_leaf = (lvl == 2'd0) || (size_bit && (int'(lvl) <= HUGE_TOP));
    end
endmodule

// File: rtl/pgw_perm_acc.sv
`timescale 1ns/1ps
module pgw_perm_acc
    import pgw_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  upd,
    input  perm_t ent,
    output perm_t acc,
    output perm_t eff
);
    always_comb begin
        eff.wr  = acc.wr  & ent.wr;
        eff.usr = acc.usr & ent.usr;
        eff.nx  = acc.nx  | ent.nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '{wr: 1'b1, usr: 1'b1, nx: 1'b0};
        end else if (clr) begin
            acc <= '{wr: 1'b1, usr: 1'b1, nx: 1'b0};
        end else if (upd) begin
            acc <= eff;
        end
    end
endmodule

// File: rtl/pgw_top.sv
`timescale 1ns/1ps
module pgw_top
    import pgw_pkg::*;
#(
    parameter int VA_W     = 64,
    parameter int PA_W     = 52,
    parameter int OFF_W    = 12,
    parameter int IDX_W    = 9,
    parameter int HUGE_TOP = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [VA_W-1:0]       req_vaddr,
    input  logic                  req_write,
    input  logic                  req_exec,
    input  logic                  req_user,
    input  logic [PA_W-OFF_W-1:0] root_frame,
    output logic                  busy,
    output logic                  mem_req_valid,
    output logic [PA_W-1:0]       mem_req_addr,
    input  logic                  mem_rsp_valid,
    input  logic [63:0]           mem_rsp_data,
    output logic                  done_valid,
    output logic                  done_fault,
    output logic [1:0]            fault_code,
    output logic [VA_W-1:0]       fault_vaddr,
    output logic [PA_W-1:0]       done_paddr,
    output logic                  done_writable,
    output logic                  done_user,
    output logic                  done_noexec
);
    localparam int FRAME_W = PA_W - OFF_W;
    localparam int IMPL_W  = OFF_W + WALK_LEVELS*IDX_W;
    localparam int LOW_W   = OFF_W + HUGE_TOP*IDX_W;

    walk_st_e st_q, st_d;
    logic               wait_q;
    logic [VA_W-1:0]    va_q;
    logic               wr_q, ex_q, us_q;
    logic [FRAME_W-1:0] frame_q;
    fault_e             code_q;
    logic [PA_W-1:0]    pa_q;

    // request side: canonical form check
    logic [VA_W-IMPL_W:0] ext_bits;
    logic                 canon_req;
    always_comb begin
        ext_bits  = req_vaddr[VA_W-1:IMPL_W-1];
        canon_req = (&ext_bits) | ~(|ext_bits);
    end

    // level decode
    logic     in_walk;
    logic [1:0] lvl;
    walk_st_e st_below;
    always_comb begin
        in_walk  = 1'b1;
        lvl      = 2'd0;
        st_below = ST_IDLE;
        unique case (st_q)
            ST_L4:   begin lvl = 2'd3; st_below = ST_L3; end
            ST_L3:   begin lvl = 2'd2; st_below = ST_L2; end
            ST_L2:   begin lvl = 2'd1; st_below = ST_L1; end
            ST_L1:   begin lvl = 2'd0; st_below = ST_IDLE; end
            default: in_walk = 1'b0;
        endcase
    end

    // entry fields
    logic               ent_present;
    logic [FRAME_W-1:0] ent_frame;
    perm_t              ent_perm;
    logic               unused_ent_bits;
    always_comb begin
        ent_present     = mem_rsp_data[BIT_PRESENT];
        ent_frame       = mem_rsp_data[PA_W-1:OFF_W];
        ent_perm.wr     = mem_rsp_data[BIT_WRITE];
        ent_perm.usr    = mem_rsp_data[BIT_USER];
        ent_perm.nx     = mem_rsp_data[BIT_NOEXEC];
        unused_ent_bits = ^{mem_rsp_data[ENT_W-2:PA_W],
                            mem_rsp_data[OFF_W-1:BIT_LEAF+1],
                            mem_rsp_data[BIT_LEAF-1:BIT_USER+1]};
    end

    // index extraction and entry address
    logic [WALK_LEVELS-1:0][IDX_W-1:0] idx;
    pgw_index #(
        .VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(WALK_LEVELS)
    ) u_index (
        .va_idx_bits (va_q[IMPL_W-1:OFF_W]),
        .idx         (idx)
    );

    logic [PA_W-1:0] ent_addr;
    pgw_addr_gen #(
        .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)
    ) u_addr (
        .table_frame (frame_q),
        .idx         (idx[lvl]),
        .entry_addr  (ent_addr)
    );

    // leaf detection and output address
    logic [PA_W-1:0] leaf_pa;
    logic            is_leaf;
    pgw_leaf #(
        .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .HUGE_TOP(HUGE_TOP)
    ) u_leaf (
        .frame    (ent_frame),
        .va_low   (va_q[LOW_W-1:0]),
        .size_bit (mem_rsp_data[BIT_LEAF]),
        .lvl      (lvl),
        .leaf_pa  (leaf_pa),
        .is_leaf  (is_leaf)
    );

    // permission merge along the path
    logic  accept, rsp_take;
    perm_t perm_acc, perm_eff;
    always_comb begin
        accept   = (st_q == ST_IDLE) && req_valid;
        rsp_take = in_walk && wait_q && mem_rsp_valid;
    end

    pgw_perm_acc u_perm (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .upd   (rsp_take && ent_present),
        .ent   (ent_perm),
        .acc   (perm_acc),
        .eff   (perm_eff)
    );

    logic viol_write, viol_priv;
    always_comb begin
        viol_write = wr_q && !perm_eff.wr;
        viol_priv  = (us_q && !perm_eff.usr) || (ex_q && perm_eff.nx);
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (req_valid) st_d = canon_req ? ST_L4 : ST_FAULT;
            end
            ST_L4, ST_L3, ST_L2, ST_L1: begin
                if (rsp_take) begin
                    if (!ent_present)                 st_d = ST_FAULT;
                    else if (is_leaf)                 st_d = (viol_write || viol_priv) ? ST_FAULT : ST_DONE;
                    else                              st_d = st_below;
                end
            end
            ST_DONE, ST_FAULT: st_d = ST_IDLE;
            default:           st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // walk context and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_q  <= 1'b0;
            va_q    <= '0;
            wr_q    <= 1'b0;
            ex_q    <= 1'b0;
            us_q    <= 1'b0;
            frame_q <= '0;
            code_q  <= FC_NONCANON;
            pa_q    <= '0;
        end else if (accept) begin
            va_q    <= req_vaddr;
            wr_q    <= req_write;
            ex_q    <= req_exec;
            us_q    <= req_user;
            frame_q <= root_frame;
            wait_q  <= 1'b0;
            code_q  <= FC_NONCANON;
            pa_q    <= '0;
        end else if (in_walk && !wait_q) begin
            wait_q <= 1'b1;
        end else if (rsp_take) begin
            wait_q  <= 1'b0;
            frame_q <= ent_frame;
            if (!ent_present) begin
                code_q <= FC_ABSENT;
            end else if (is_leaf) begin
                if (viol_write)     code_q <= FC_WRITE;
                else if (viol_priv) code_q <= FC_PRIV;
                else                pa_q   <= leaf_pa;
            end
        end
    end

    // outputs
    always_comb begin
        busy          = (st_q != ST_IDLE);
        mem_req_valid = in_walk && !wait_q;
        mem_req_addr  = ent_addr;
        done_valid    = (st_q == ST_DONE) || (st_q == ST_FAULT);
        done_fault    = (st_q == ST_FAULT);
        fault_code    = (st_q == ST_FAULT) ? code_q : FC_NONCANON;
        fault_vaddr   = (st_q == ST_FAULT) ? va_q : '0;
        done_paddr    = (st_q == ST_DONE) ? pa_q : '0;
        done_writable = (st_q == ST_DONE) && perm_acc.wr;
        done_user     = (st_q == ST_DONE) && perm_acc.usr;
        done_noexec   = (st_q == ST_DONE) && perm_acc.nx;
    end
endmodule

// File: rtl/pgw_chk.sv
`timescale 1ns/1ps
module pgw_chk #(
    parameter int VA_W  = 64,
    parameter int OFF_W = 12,
    parameter int IDX_W = 9
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [VA_W-1:0] req_vaddr,
    input logic            busy,
    input logic            mem_req_valid,
    input logic            done_valid,
    input logic            done_fault,
    input logic [1:0]      fault_code,
    input logic [VA_W-1:0] fault_vaddr
);
    localparam int IMPL_W = OFF_W + 4*IDX_W;

    logic [VA_W-IMPL_W:0] top_bits;
    logic                 is_canon;
    always_comb begin
        top_bits = req_vaddr[VA_W-1:IMPL_W-1];
        is_canon = (&top_bits) | ~(|top_bits);
    end

    logic [VA_W-1:0] taken_va_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  taken_va_q <= '0;
        else if (!busy && req_valid) taken_va_q <= req_vaddr;
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req_valid && !done_valid));

    // R2
    noncanon_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && !is_canon) |=> (done_valid && done_fault && fault_code == 2'd0 && !mem_req_valid));

    // R11
    single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R11
    done_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> busy);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    // R5
    fault_va_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_fault) |-> (fault_vaddr == taken_va_q));

    // R8
    clean_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !done_fault) |-> (fault_code == 2'd0));
endmodule

bind pgw_top pgw_chk #(
    .VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)
) u_pgw_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .done_valid    (done_valid),
    .done_fault    (done_fault),
    .fault_code    (fault_code),
    .fault_vaddr   (fault_vaddr)
);

// File: tb/tb_pgw_top.sv
`timescale 1ns/1ps
module tb_pgw_top;
    localparam int VA_W = 64;
    localparam int PA_W = 52;
    localparam int FRAME_W = PA_W - 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [VA_W-1:0] req_vaddr = '0;
    logic req_write = 1'b0, req_exec = 1'b0, req_user = 1'b0;
    logic [FRAME_W-1:0] root_frame = 40'h1;
    logic busy, mem_req_valid, done_valid, done_fault;
    logic [PA_W-1:0] mem_req_addr, done_paddr;
    logic mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic [1:0] fault_code;
    logic [VA_W-1:0] fault_vaddr;
    logic done_writable, done_user, done_noexec;

    always #2 clk = ~clk;

    pgw_top dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_exec(req_exec), .req_user(req_user),
        .root_frame(root_frame), .busy(busy), .mem_req_valid(mem_req_valid),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done_valid(done_valid), .done_fault(done_fault),
        .fault_code(fault_code), .fault_vaddr(fault_vaddr), .done_paddr(done_paddr),
        .done_writable(done_writable), .done_user(done_user), .done_noexec(done_noexec)
    );

    // memory model: 32 KB of tables, one response two cycles after each read
    logic [63:0] tmem [0:4095];
    int nreads = 0;
    logic [PA_W-1:0] alog [0:3];
    logic pend = 1'b0;
    int lat = 0;
    logic [PA_W-1:0] rd_addr;
    initial begin
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
    end
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid) begin
            pend <= 1'b1;
            lat <= 1;
            rd_addr <= mem_req_addr;
            alog[nreads % 4] <= mem_req_addr;
            nreads <= nreads + 1;
        end else if (pend) begin
            if (lat == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data <= (rd_addr < 52'h8000) ? tmem[rd_addr[14:3]] : 64'h0;
                pend <= 1'b0;
            end else begin
                lat <= lat - 1;
            end
        end
    end

    task automatic put(input int tbl, input int idx, input logic [63:0] val);
        tmem[(tbl + idx*8) >> 3] = val;
    endtask

    int checks = 0;
    int errors = 0;

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    logic r_flt, r_w, r_u, r_nx;
    logic [1:0] r_code;
    logic [PA_W-1:0] r_pa;
    logic [VA_W-1:0] r_fva;
    int r_reads, r_first;

    task automatic do_walk(input logic [63:0] va, input logic wr, input logic ex, input logic us);
        int start;
        int t;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr; req_exec = ex; req_user = us;
        start = nreads;
        r_first = start % 4;
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (!done_valid && t < 2000) begin
            @(negedge clk);
            t++;
        end
        if (!done_valid) chk(1'b0, "R11", "walk timeout", 0, 1);
        r_flt = done_fault; r_code = fault_code; r_pa = done_paddr; r_fva = fault_vaddr;
        r_w = done_writable; r_u = done_user; r_nx = done_noexec;
        r_reads = nreads - start;
        @(negedge clk);
        chk(!done_valid && !busy, "R12", "done not single pulse", {62'b0, done_valid, busy}, 0);
    endtask

    typedef struct packed {
        logic [63:0] va;
        logic wr, ex, us, flt;
        logic [1:0] code;
        logic [51:0] pa;
        logic w, u, nx;
        logic [2:0] reads;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{64'h0000_0080_3FE7_F5CE, 1'b0,1'b0,1'b1, 1'b0,2'd0, 52'hC5CE,        1'b0,1'b1,1'b0, 3'd4}, // R4
        '{64'h0000_0080_3FE7_F5CE, 1'b1,1'b0,1'b1, 1'b1,2'd2, 52'h0,           1'b0,1'b0,1'b0, 3'd4}, // R8
        '{64'h0000_0080_3FE7_E123, 1'b0,1'b1,1'b0, 1'b1,2'd3, 52'h0,           1'b0,1'b0,1'b0, 3'd4}, // R9 exec
        '{64'h0000_0080_3FE7_E123, 1'b0,1'b0,1'b0, 1'b0,2'd0, 52'hD123,        1'b1,1'b1,1'b1, 3'd4}, // R10 nx
        '{64'h0000_0080_3FE7_D000, 1'b0,1'b0,1'b0, 1'b1,2'd1, 52'h0,           1'b0,1'b0,1'b0, 3'd4}, // R5 level 1
        '{64'h0000_0080_3FC1_2345, 1'b1,1'b0,1'b1, 1'b0,2'd0, 52'h4001_2345,   1'b1,1'b1,1'b0, 3'd3}, // R7
        '{64'h0000_0080_5234_5678, 1'b0,1'b0,1'b0, 1'b0,2'd0, 52'h1_5234_5678, 1'b1,1'b0,1'b0, 3'd2}, // R6
        '{64'h0000_0080_5234_5678, 1'b0,1'b0,1'b1, 1'b1,2'd3, 52'h0,           1'b0,1'b0,1'b0, 3'd2}, // R9 user
        '{64'h0000_0100_0000_0010, 1'b1,1'b0,1'b0, 1'b1,2'd2, 52'h0,           1'b0,1'b0,1'b0, 3'd4}, // R8 top-level restriction
        '{64'h0000_0100_0000_0010, 1'b0,1'b0,1'b1, 1'b0,2'd0, 52'hE010,        1'b0,1'b1,1'b0, 3'd4}, // R10
        '{64'h0000_0180_0000_0000, 1'b0,1'b0,1'b0, 1'b1,2'd1, 52'h0,           1'b0,1'b0,1'b0, 3'd1}, // R5 level 4
        '{64'h0001_0000_0000_0000, 1'b0,1'b0,1'b0, 1'b1,2'd0, 52'h0,           1'b0,1'b0,1'b0, 3'd0}, // R2
        '{64'hFFFF_8000_0000_0000, 1'b0,1'b0,1'b0, 1'b1,2'd1, 52'h0,           1'b0,1'b0,1'b0, 3'd1}, // R2 canonical high half
        '{64'h0000_0200_3FE7_F5CE, 1'b0,1'b0,1'b0, 1'b0,2'd0, 52'hC5CE,        1'b0,1'b1,1'b0, 3'd4}, // R6 size bit at level 4
        '{64'h0000_0080_3FE7_C000, 1'b1,1'b0,1'b1, 1'b1,2'd2, 52'h0,           1'b0,1'b0,1'b0, 3'd4}, // R9 priority
        '{64'h8000_0000_0000_0000, 1'b0,1'b0,1'b0, 1'b1,2'd0, 52'h0,           1'b0,1'b0,1'b0, 3'd0}  // R2
    };

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        string tag;
        int dones;
        for (int i = 0; i < 4096; i++) tmem[i] = 64'h0;
        put(32'h1000, 1, 64'h2007);
        put(32'h1000, 2, 64'h5005);
        put(32'h1000, 4, 64'h2087);
        put(32'h2000, 0, 64'h3007);
        put(32'h2000, 1, 64'h1_4000_0083);
        put(32'h3000, 511, 64'h4007);
        put(32'h3000, 510, 64'h4000_0087);
        put(32'h4000, 127, 64'hC005);
        put(32'h4000, 126, 64'h8000_0000_0000_D007);
        put(32'h4000, 124, 64'hF001);
        put(32'h5000, 0, 64'h6007);
        put(32'h6000, 0, 64'h7007);
        put(32'h7000, 0, 64'hE007);

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req_valid && !done_valid, "R1", "outputs in reset",
            {61'b0, busy, mem_req_valid, done_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !mem_req_valid && !done_valid, "R1", "outputs after reset",
            {61'b0, busy, mem_req_valid, done_valid}, 0);

        for (int i = 0; i < NV; i++) begin
            do_walk(VECS[i].va, VECS[i].wr, VECS[i].ex, VECS[i].us);
            if (!VECS[i].flt)
                tag = (VECS[i].reads == 3) ? "R7" : (VECS[i].reads == 2) ? "R6" : "R4";
            else
                case (VECS[i].code)
                    2'd0:    tag = "R2";
                    2'd1:    tag = "R5";
                    2'd2:    tag = "R8";
                    default: tag = "R9";
                endcase
            chk(r_flt == VECS[i].flt, tag, "fault flag", {63'b0, r_flt}, {63'b0, VECS[i].flt});
            chk(r_code == VECS[i].code, tag, "fault code", {62'b0, r_code}, {62'b0, VECS[i].code});
            chk(r_reads == int'(VECS[i].reads), "R3", "entry read count", r_reads, VECS[i].reads);
            if (VECS[i].flt) begin
                chk(r_fva == VECS[i].va, "R5", "fault address", r_fva, VECS[i].va);
            end else begin
                chk(r_pa == VECS[i].pa, tag, "physical address", {12'b0, r_pa}, {12'b0, VECS[i].pa});
                chk({r_w, r_u, r_nx} == {VECS[i].w, VECS[i].u, VECS[i].nx}, "R10", "merged permissions",
                    {61'b0, r_w, r_u, r_nx}, {61'b0, VECS[i].w, VECS[i].u, VECS[i].nx});
            end
            if (i == 0) begin
                // R3: entry addresses of the four reads for 0x803FE7F5CE
                chk(alog[(r_first + 0) % 4] == 52'h1008, "R3", "level-4 entry address", {12'b0, alog[(r_first + 0) % 4]}, 64'h1008);
                chk(alog[(r_first + 1) % 4] == 52'h2000, "R3", "level-3 entry address", {12'b0, alog[(r_first + 1) % 4]}, 64'h2000);
                chk(alog[(r_first + 2) % 4] == 52'h3FF8, "R3", "level-2 entry address", {12'b0, alog[(r_first + 2) % 4]}, 64'h3FF8);
                chk(alog[(r_first + 3) % 4] == 52'h43F8, "R3", "level-1 entry address", {12'b0, alog[(r_first + 3) % 4]}, 64'h43F8);
            end
        end

        // R11: a second request offered mid-walk is dropped
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 64'h0000_0080_3FE7_F5CE;
        req_write = 1'b0; req_exec = 1'b0; req_user = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy, "R11", "busy during walk", {63'b0, busy}, 1);
        req_valid = 1'b1; req_vaddr = 64'h0001_0000_0000_0000;
        @(negedge clk);
        req_valid = 1'b0;
        dones = 0;
        for (int t = 0; t < 200 && !done_valid; t++) @(negedge clk);
        chk(done_valid && !done_fault && done_paddr == 52'hC5CE, "R11", "result of first request",
            {11'b0, done_fault, done_paddr}, 64'hC5CE);
        @(negedge clk);
        for (int t = 0; t < 20; t++) begin
            if (done_valid) dones++;
            @(negedge clk);
        end
        chk(dones == 0, "R11", "dropped request produced a result", dones, 0);

        // R1: reset in the middle of a walk returns to idle
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 64'h0000_0080_3FE7_F5CE;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !mem_req_valid && !done_valid, "R1", "outputs after mid-walk reset",
            {61'b0, busy, mem_req_valid, done_valid}, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(!busy && !done_valid, "R1", "idle after reset release", {62'b0, busy, done_valid}, 0);

        // R4: walk still correct after the interrupted one
        do_walk(64'h0000_0080_3FE7_F5CE, 1'b0, 1'b0, 1'b0);
        chk(!r_flt && r_pa == 52'hC5CE, "R4", "translation after reset", {12'b0, r_pa}, 64'hC5CE);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule